// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers the stage registers and program counter of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It has two jobs. The first is redirecting on a taken branch or jump. The second is stalling on a load whose result the very next instruction needs. The decision logic is purely combinational. Its outputs drive the write-enable (keep-when-low) and synchronous-clear inputs of the stage registers, plus a three-way next-PC selector.

Transfers are resolved late. The taken flag is read from the execute/memory register. A redirect therefore discards the three younger instructions that sit in fetch/decode, decode/execute and execute/memory, and it overrides any load-use stall seen in the same cycle. A cleared stage entry is all zeros and behaves as a no-op. The top level wraps the unit in a small model of the four stage registers and the PC. It takes one packed instruction descriptor per fetch address and exposes the entry leaving the memory stage, so that the control can be exercised at the ports.

Top module: `hazard_pipe`

## Requirements
- R1: Descriptor layout, one packed word of 35 bits. Bit 34 marks a taken transfer and bit 33 marks a load. Bits 32:28 hold the destination register, 27:23 the first source, 22:18 the second source, 17:10 an identifier and 9:0 the transfer target byte address. A descriptor that is neither flushed nor squashed reaches `retire_word` unchanged, four fetch cycles later.
- R2: When decode/execute holds a load with a nonzero destination that equals either source of the instruction in fetch/decode, `pc_hold` and `ifid_hold` are high and `idex_flush` clears decode/execute for exactly one cycle. `pc_sel` is then 1 (hold), the PC keeps its value, and the consumer retires two cycles after the load instead of one.
- R3: A load whose destination is register 0 never causes a stall.
- R4: A load whose consumer is two or more instructions behind it causes no stall.
- R5: A non-load producer followed directly by a consumer causes no stall.
- R6: When execute/memory holds a taken transfer, `pc_sel` is 2 (target). The next PC is the target, and fetch/decode, decode/execute and execute/memory are all cleared. The three instructions after the transfer never retire, and the target instruction retires four cycles after the transfer.
- R7: A taken transfer overrides a load-use match in the same cycle: no stall cycle occurs.
- R8: A cleared entry retires as an all-zero word, and a held fetch/decode entry keeps its contents.
- R9: While reset is high, the PC is 0, `retire_word` is 0, `pc_sel` is 0 (sequential) and every hold and flush output is low. With no condition active, the PC advances by 4 each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 35 | Descriptor at the current PC |
| pc | output | 10 | Current fetch address |
| retire_word | output | 35 | Entry leaving the memory stage |
| pc_sel | output | 2 | Next-PC choice: 0 sequential, 1 hold, 2 target |
| pc_hold | output | 1 | PC stall |
| ifid_hold | output | 1 | Fetch/decode register keeps its value |
| ifid_flush | output | 1 | Fetch/decode register cleared |
| idex_flush | output | 1 | Decode/execute register cleared |
| exmem_flush | output | 1 | Execute/memory register cleared |

## Verification
A redirect and a load-use stall can both be requested in the same cycle. This happens when a taken transfer reaches execute/memory while a load sits behind it in decode/execute and a consumer of that load sits in fetch/decode. The bench builds exactly that program. It requires that the hold signal stays low for the whole run, that the retire sequence jumps straight from the transfer to its target four cycles later, and that neither the load nor its consumer ever appears. Sweeps over destination and source register choices, and over transfer positions and targets, give the expected retire order and spacing by arithmetic on the program.

// File: rtl/hzp_pkg.sv
package hzp_pkg;
  localparam int REG_W = 5;
  localparam int ID_W  = 8;
  localparam int PC_W  = 10;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_HOLD = 2'd1,
    PC_JUMP = 2'd2
  } pc_sel_e;

  typedef struct packed {
    logic             taken;
    logic             load;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [ID_W-1:0]  id;
    logic [PC_W-1:0]  tgt;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);
endpackage

// File: rtl/hz_detect.sv
module hz_detect import hzp_pkg::*; (
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             ex_load,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             mem_taken,
  output pc_sel_e          pc_sel,
  output logic             pc_hold,
  output logic             if_hold,
  output logic             if_clr,
  output logic             id_clr,
  output logic             ex_clr
);
  logic use_match;
  assign use_match = ex_load && (ex_rd != '0) &&
                     ((ex_rd == dec_rs1) || (ex_rd == dec_rs2));

  always_comb begin
    pc_sel  = PC_SEQ;
    pc_hold = 1'b0;
    if_hold = 1'b0;
    if_clr  = 1'b0;
    id_clr  = 1'b0;
    ex_clr  = 1'b0;
    if (mem_taken) begin
      pc_sel = PC_JUMP;
      if_clr = 1'b1;
      id_clr = 1'b1;
      ex_clr = 1'b1;
    end else if (use_match) begin
      pc_sel  = PC_HOLD;
      pc_hold = 1'b1;
      if_hold = 1'b1;
      id_clr  = 1'b1;
    end
  end

  always_comb begin
    // R3
    if (ex_rd == '0) x0_no_stall_chk: assert (!pc_hold);
    // R7
    if (mem_taken) redirect_wins_chk: assert (!pc_hold && !if_hold);
  end
endmodule

// File: rtl/pl_stage.sv
module pl_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= d;
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit import hzp_pkg::*; #(
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  pc_sel_e         sel,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] INC = PC_W'(STEP);
  logic [PC_W-1:0] nxt;

  always_comb begin
    case (sel)
      PC_HOLD: nxt = pc;
      PC_JUMP: nxt = tgt;
      default: nxt = pc + INC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nxt;
  end
endmodule

// File: rtl/hazard_pipe.sv
module hazard_pipe import hzp_pkg::*; #(
  parameter int STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] fetch_word,
  output logic [PC_W-1:0]   pc,
  output logic [SLOT_W-1:0] retire_word,
  output logic [1:0]        pc_sel,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_flush,
  output logic              idex_flush,
  output logic              exmem_flush
);
  localparam int NSTG = 4;

  slot_t   stg_d [NSTG];
  slot_t   stg_q [NSTG];
  logic [NSTG-1:0] stg_en, stg_clr;
  pc_sel_e sel_w;

  hz_detect u_hz (
    .dec_rs1  (stg_q[0].rs1),
    .dec_rs2  (stg_q[0].rs2),
    .ex_load  (stg_q[1].load),
    .ex_rd    (stg_q[1].rd),
    .mem_taken(stg_q[2].taken),
    .pc_sel   (sel_w),
    .pc_hold  (pc_hold),
    .if_hold  (ifid_hold),
    .if_clr   (ifid_flush),
    .id_clr   (idex_flush),
    .ex_clr   (exmem_flush)
  );

  pc_unit #(.STEP(STEP)) u_pc (
    .clk(clk), .rst(rst), .sel(sel_w), .tgt(stg_q[2].tgt), .pc(pc)
  );

  assign stg_en  = {1'b1, 1'b1, 1'b1, !ifid_hold};
  assign stg_clr = {1'b0, exmem_flush, idex_flush, ifid_flush};

  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_stage
      if (g == 0) begin : g_head
        assign stg_d[g] = slot_t'(fetch_word);
      end else begin : g_link
        assign stg_d[g] = stg_q[g-1];
      end
      pl_stage #(.W(SLOT_W)) u_reg (
        .clk(clk), .rst(rst), .en(stg_en[g]), .clr(stg_clr[g]),
        .d(stg_d[g]), .q(stg_q[g])
      );
    end
  endgenerate

  assign retire_word = stg_q[NSTG-1];
  assign pc_sel      = sel_w;

  // R2
  pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> pc == $past(pc));
  // R2
  stall_once_chk: assert property (@(posedge clk) disable iff (rst)
    pc_hold |=> !pc_hold);
  // R8
  ifid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ifid_hold |=> stg_q[0] == $past(stg_q[0]));
  // R6
  squash_chk: assert property (@(posedge clk) disable iff (rst)
    stg_q[2].taken |=> (stg_q[0] == '0 && stg_q[1] == '0 && stg_q[2] == '0
                        && pc == $past(stg_q[2].tgt)));
  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!pc_hold && !stg_q[2].taken) |=> pc == $past(pc) + PC_W'(STEP));
endmodule

// File: tb/hazard_pipe_test.sv
`timescale 1ns/1ps
module hazard_pipe_test;
  import hzp_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SLOT_W-1:0] fetch_word, retire_word;
  logic [PC_W-1:0] pc;
  logic [1:0] pc_sel;
  logic pc_hold, ifid_hold, ifid_flush, idex_flush, exmem_flush;

  logic [SLOT_W-1:0] prog [0:31];
  int n_chk = 0, n_fail = 0;
  int ret_id [0:63];
  int ret_c  [0:63];
  logic [SLOT_W-1:0] ret_w [0:63];
  logic [SLOT_W-1:0] wb_at [0:63];
  int n_ret, n_hold;
  int exp_id [0:63];
  int exp_gap [0:63];
  int n_exp;

  always #2.5 clk = ~clk;

  assign fetch_word = (pc[PC_W-1:2] < 32) ? prog[pc[6:2]] : '0;

  hazard_pipe uut (
    .clk(clk), .rst(rst), .fetch_word(fetch_word), .pc(pc),
    .retire_word(retire_word), .pc_sel(pc_sel), .pc_hold(pc_hold),
    .ifid_hold(ifid_hold), .ifid_flush(ifid_flush),
    .idex_flush(idex_flush), .exmem_flush(exmem_flush)
  );

  function automatic logic [SLOT_W-1:0] mk(input bit tk, input bit ld,
      input int rd, input int a, input int b, input int id, input int tgt);
    slot_t s;
    s.taken = tk; s.load = ld;
    s.rd = REG_W'(rd); s.rs1 = REG_W'(a); s.rs2 = REG_W'(b);
    s.id = ID_W'(id); s.tgt = PC_W'(tgt);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = '0;
  endtask

  task automatic run_prog(input int ncyc);
    slot_t s;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    n_ret = 0; n_hold = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      wb_at[c] = retire_word;
      if (pc_hold) n_hold++;
      if (retire_word != '0) begin
        s = slot_t'(retire_word);
        ret_id[n_ret] = int'(s.id);
        ret_c[n_ret]  = c;
        ret_w[n_ret]  = retire_word;
        n_ret++;
      end
    end
  endtask

  task automatic cmp_seq(input string req);
    chk(n_ret == n_exp, req, n_ret, n_exp);
    for (int i = 0; i < n_exp && i < n_ret; i++) begin
      chk(ret_id[i] == exp_id[i], req, ret_id[i], exp_id[i]);
      if (i > 0) chk(ret_c[i] - ret_c[i-1] == exp_gap[i], req,
                     ret_c[i] - ret_c[i-1], exp_gap[i]);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int regs [4] = '{0, 3, 17, 31};
    int bpos [3] = '{0, 1, 3};
    int toff [3] = '{1, 4, 6};

    // R9: reset state
    clear_prog();
    for (int i = 0; i < 8; i++) prog[i] = mk(0, 1, 4, 4, 4, i + 1, 0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(pc == '0, "R9 pc", pc, 0);
    chk(retire_word == '0, "R9 retire", retire_word, 0);
    chk(pc_sel == 2'd0, "R9 sel", pc_sel, 0);
    chk({pc_hold, ifid_hold, ifid_flush, idex_flush, exmem_flush} == 5'b0,
        "R9 ctl", {pc_hold, ifid_hold, ifid_flush, idex_flush, exmem_flush}, 0);
    // R9: sequential PC step
    rst = 1'b0;
    @(negedge clk);
    chk(pc == 10'd4, "R9 step", pc, 4);

    // R5, R1: ALU chain with dependences, no stall
    clear_prog();
    for (int i = 0; i < 6; i++) prog[i] = mk(0, 0, i + 1, i, i, i + 1, 0);
    run_prog(20);
    n_exp = 6;
    for (int i = 0; i < 6; i++) begin exp_id[i] = i + 1; exp_gap[i] = 1; end
    cmp_seq("R5");
    chk(n_hold == 0, "R5 holds", n_hold, 0);
    chk(ret_w[2] == prog[2], "R1 word", ret_w[2], prog[2]);

    // R2, R3, R8: load-use sweep over destination and sources
    foreach (regs[a]) foreach (regs[b]) foreach (regs[c]) begin
      int rd, s1, s2;
      bit stall;
      rd = regs[a]; s1 = regs[b]; s2 = regs[c];
      stall = (rd != 0) && (rd == s1 || rd == s2);
      clear_prog();
      prog[0] = mk(0, 1, rd, 0, 0, 1, 0);
      prog[1] = mk(0, 0, 2, s1, s2, 2, 0);
      prog[2] = mk(0, 0, 3, 0, 0, 3, 0);
      run_prog(14);
      n_exp = 3;
      exp_id[0] = 1; exp_id[1] = 2; exp_id[2] = 3;
      exp_gap[1] = stall ? 2 : 1; exp_gap[2] = 1;
      cmp_seq(rd == 0 ? "R3" : "R2");
      chk(n_hold == (stall ? 1 : 0), rd == 0 ? "R3 holds" : "R2 holds",
          n_hold, stall ? 1 : 0);
      if (stall && n_ret == 3) begin
        chk(wb_at[ret_c[0] + 1] == '0, "R8 bubble", wb_at[ret_c[0] + 1], 0);
        chk(ret_w[1] == prog[1], "R8 held", ret_w[1], prog[1]);
      end
    end

    // R4: consumer two behind the load
    clear_prog();
    prog[0] = mk(0, 1, 7, 0, 0, 1, 0);
    prog[1] = mk(0, 0, 2, 0, 0, 2, 0);
    prog[2] = mk(0, 0, 3, 7, 7, 3, 0);
    run_prog(14);
    n_exp = 3;
    for (int i = 0; i < 3; i++) begin exp_id[i] = i + 1; exp_gap[i] = 1; end
    cmp_seq("R4");
    chk(n_hold == 0, "R4 holds", n_hold, 0);

    // R6: taken transfer sweep over position and target
    foreach (bpos[p]) foreach (toff[t]) begin
      int bi, ti, k;
      bi = bpos[p]; ti = bi + toff[t];
      clear_prog();
      for (int i = 0; i < 12; i++) prog[i] = mk(0, 0, 1, 0, 0, i + 1, 0);
      prog[bi] = mk(1, 0, 0, 0, 0, bi + 1, ti * 4);
      run_prog(30);
      k = 0;
      for (int i = 0; i <= bi; i++) begin exp_id[k] = i + 1; exp_gap[k] = 1; k++; end
      for (int i = ti; i < 12; i++) begin
        exp_id[k] = i + 1; exp_gap[k] = (i == ti) ? 4 : 1; k++;
      end
      n_exp = k;
      cmp_seq("R6");
      chk(n_hold == 0, "R6 holds", n_hold, 0);
    end

    // R7: load-use pair behind a taken transfer
    clear_prog();
    for (int i = 0; i < 12; i++) prog[i] = mk(0, 0, 1, 0, 0, i + 1, 0);
    prog[1] = mk(1, 0, 0, 0, 0, 2, 8 * 4);
    prog[2] = mk(0, 1, 9, 0, 0, 3, 0);
    prog[3] = mk(0, 0, 4, 0, 9, 4, 0);
    run_prog(30);
    n_exp = 6;
    exp_id[0] = 1; exp_id[1] = 2; exp_gap[1] = 1;
    for (int i = 0; i < 4; i++) begin exp_id[2 + i] = 9 + i; exp_gap[2 + i] = (i == 0) ? 4 : 1; end
    cmp_seq("R7");
    chk(n_hold == 0, "R7 holds", n_hold, 0);

    summary();
    $finish;
  end
endmodule